// File: doc/BRIEF.md
# Clock Generator Interrupt Flag Logic

This block collects the interrupt sources of a clock and reset generator and turns them into three separate interrupt requests. The sources are a periodic real-time tick produced by a down-counter with a programmable period, any change of the PLL lock status, and any change of the self-clock (fallback oscillator) status. The lock and self-clock status arrive from analog or other clock-domain logic. They are resynchronised, and a flag is raised on every transition in either direction.

Software uses a small register bus with two word addresses. One word holds the enable bits, the pseudo-stop run bit and the clock-monitor enable bit. The other holds the three write-one-to-clear flags. Each request is the flag gated by its enable, so a masked source is still recorded in its flag. The tick counter stops in full stop. In pseudo-stop it keeps counting only when software has set the run bit, and this gives a periodic wakeup.

Top module: `cgen_irq_ctrl`

## Requirements
- R1: With the counter running and a period value P on `tick_period`, the tick flag (flag word bit 0) sets every P+1 clock cycles. Counting starts from release of the hold, and the period value is reloaded at each timeout.
- R2: Writing 1 to a bit of the flag word (address 1) clears that flag in the next cycle. Writing 0 to a bit leaves that flag unchanged.
- R3: If a hardware set event and a software clear reach the same flag in the same cycle, the flag stays set.
- R4: Each request output is 1 exactly when its flag and its enable are both 1. The enables are control word (address 0) bit 0 for tick, bit 1 for lock and bit 2 for self-clock. A flag still sets while its enable is 0.
- R5: While `full_stop` is 1 the tick counter is held at the period value and the tick flag never sets.
- R6: While `pseudo_stop` is 1, the tick counter runs only if the control word bit 3 (pseudo-stop run) is 1. When it runs, it times out P+1 cycles after the bit is written.
- R7: The lock flag (flag word bit 1) sets on both a rise and a fall of `lock_raw`, three clock edges after the input changes.
- R8: The self-clock flag (flag word bit 2) sets on both entry to and exit from self-clock mode, three clock edges after `scm_raw` changes.
- R9: When control word bit 4 (clock-monitor enable) is 1, `ext_clk_lost` = 1 forces the self-clock status to 1. When the bit is 0, `ext_clk_lost` has no effect on the self-clock flag.
- R10: `bus_rdata` shows the control word at address 0 and the flag word at address 1, with unused bits reading 0. Both words are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lock_raw | input | 1 | Unsynchronised PLL lock status |
| scm_raw | input | 1 | Unsynchronised self-clock mode status |
| ext_clk_lost | input | 1 | Unsynchronised loss-of-external-clock indication |
| full_stop | input | 1 | Full stop mode active |
| pseudo_stop | input | 1 | Pseudo-stop mode active |
| tick_period | input | PW | Tick timeout value P (period is P+1 cycles) |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | Word select: 0 control, 1 flags |
| bus_wdata | input | 5 | Write data |
| bus_rdata | output | 5 | Read data of the selected word |
| irq_tick | output | 1 | Real-time tick interrupt request |
| irq_lock | output | 1 | Lock-change interrupt request |
| irq_scm | output | 1 | Self-clock-change interrupt request |

## Verification
The lock and self-clock inputs are driven through a rise and then a fall, and the flag is sampled on the second and third edge after each change. This separates a level detector from a detector that fires on both edges, and it catches a wrong synchroniser depth. The tick counter is released from hold and the cycles until the flag appears are counted, which exposes an off-by-one in the reload. A clear write is placed on the exact timeout cycle to show which of set and clear has priority. Full stop, pseudo-stop with the run bit clear and pseudo-stop with the run bit set are each held long enough to show whether the counter was frozen. The clock-lost input is toggled with the monitor enable off and then on, to tell a gated contribution from an ungated one.

// File: rtl/cgen_irq_pkg.sv
package cgen_irq_pkg;

    localparam int NSRC     = 3;
    localparam int REG_W    = 5;
    localparam int SYNC_DEP = 2;

    localparam int FLG_TICK = 0;
    localparam int FLG_LOCK = 1;
    localparam int FLG_SCM  = 2;

    typedef enum logic {
        ADDR_CTRL  = 1'b0,
        ADDR_FLAGS = 1'b1
    } reg_addr_e;

    // packed MSB first: mon_en is bit 4, tick_ie is bit 0
    typedef struct packed {
        logic mon_en;
        logic psrun;
        logic scm_ie;
        logic lock_ie;
        logic tick_ie;
    } ctrl_t;

    function automatic logic [NSRC-1:0] enables(input ctrl_t c);
        logic [NSRC-1:0] e;
        e[FLG_TICK] = c.tick_ie;
        e[FLG_LOCK] = c.lock_ie;
        e[FLG_SCM]  = c.scm_ie;
        return e;
    endfunction

endpackage

// File: rtl/cgen_sync.sv
module cgen_sync #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [DEPTH-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[DEPTH-2:0], din};
    end

    assign dout = chain[DEPTH-1];
endmodule

// File: rtl/cgen_tick_timer.sv
module cgen_tick_timer #(
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [PW-1:0] period,
    output logic          expire
);
    logic [PW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run)       cnt <= period;
        else if (cnt == '0)    cnt <= period;
        else                   cnt <= cnt - 1'b1;
    end

    assign expire = run && !rst && (cnt == '0);
endmodule

// File: rtl/cgen_w1c_flags.sv
module cgen_w1c_flags #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flag
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)         flag[i] <= 1'b0;
            else if (set[i]) flag[i] <= 1'b1;
            else if (clr[i]) flag[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/cgen_irq_ctrl.sv
module cgen_irq_ctrl
    import cgen_irq_pkg::*;
#(
    parameter int PW = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lock_raw,
    input  logic             scm_raw,
    input  logic             ext_clk_lost,
    input  logic             full_stop,
    input  logic             pseudo_stop,
    input  logic [PW-1:0]    tick_period,
    input  logic             bus_wr,
    input  logic             bus_addr,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    output logic             irq_tick,
    output logic             irq_lock,
    output logic             irq_scm
);
    localparam int NIN = 3;

    ctrl_t           ctl;
    logic [NSRC-1:0] flags;
    logic [NSRC-1:0] set_ev;
    logic [NSRC-1:0] clr_ev;
    logic [NSRC-1:0] req;
    logic [NIN-1:0]  raw_in;
    logic [NIN-1:0]  sync_in;
    logic            lock_lvl, lock_prev, lock_chg;
    logic            scm_lvl, scm_prev, scm_chg;
    logic            tick_run, tick_exp;

    // control word
    always_ff @(posedge clk) begin
        if (rst)
            ctl <= '0;
        else if (bus_wr && bus_addr == ADDR_CTRL)
            ctl <= ctrl_t'(bus_wdata);
    end

    // status synchronisers
    assign raw_in = {ext_clk_lost, scm_raw, lock_raw};

    for (genvar k = 0; k < NIN; k++) begin : g_sync
        cgen_sync #(.DEPTH(SYNC_DEP)) u_sync (
            .clk  (clk),
            .rst  (rst),
            .din  (raw_in[k]),
            .dout (sync_in[k])
        );
    end

    assign lock_lvl = sync_in[0];
    assign scm_lvl  = sync_in[1] | (ctl.mon_en & sync_in[2]);

    // change detection on both edges
    always_ff @(posedge clk) begin
        if (rst) begin
            lock_prev <= 1'b0;
            scm_prev  <= 1'b0;
        end else begin
            lock_prev <= lock_lvl;
            scm_prev  <= scm_lvl;
        end
    end

    assign lock_chg = lock_lvl ^ lock_prev;
    assign scm_chg  = scm_lvl  ^ scm_prev;

    // real-time tick
    assign tick_run = !full_stop && (!pseudo_stop || ctl.psrun);

    cgen_tick_timer #(.PW(PW)) u_tick (
        .clk    (clk),
        .rst    (rst),
        .run    (tick_run),
        .period (tick_period),
        .expire (tick_exp)
    );

    // flags
    always_comb begin
        set_ev           = '0;
        set_ev[FLG_TICK] = tick_exp;
        set_ev[FLG_LOCK] = lock_chg;
        set_ev[FLG_SCM]  = scm_chg;
        clr_ev = (bus_wr && bus_addr == ADDR_FLAGS) ? bus_wdata[NSRC-1:0] : '0;
    end

    cgen_w1c_flags #(.N(NSRC)) u_flags (
        .clk  (clk),
        .rst  (rst),
        .set  (set_ev),
        .clr  (clr_ev),
        .flag (flags)
    );

    assign req      = flags & enables(ctl);
    assign irq_tick = req[FLG_TICK];
    assign irq_lock = req[FLG_LOCK];
    assign irq_scm  = req[FLG_SCM];

    always_comb begin
        if (bus_addr == ADDR_CTRL) bus_rdata = REG_W'(ctl);
        else                       bus_rdata = REG_W'(flags);
    end
endmodule

// File: rtl/cgen_irq_chk.sv
module cgen_irq_chk (
    input logic       clk,
    input logic       rst,
    input logic       full_stop,
    input logic       pseudo_stop,
    input logic       psrun,
    input logic       tick_exp,
    input logic       lock_chg,
    input logic       scm_chg,
    input logic [2:0] flags,
    input logic [2:0] ien,
    input logic       bus_wr,
    input logic       bus_addr,
    input logic [2:0] wdat,
    input logic       irq_tick,
    input logic       irq_lock,
    input logic       irq_scm
);
    a_r1_tick_sets_flag: assert property (@(posedge clk) disable iff (rst)
        tick_exp |=> flags[0]);

    a_r2_zero_write_keeps: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr && !wdat[1] && flags[1]) |=> flags[1]);

    a_r3_set_beats_clear: assert property (@(posedge clk) disable iff (rst)
        (tick_exp && bus_wr && bus_addr && wdat[0]) |=> flags[0]);

    a_r4_masked_quiet: assert property (@(posedge clk) disable iff (rst)
        (!ien[0] |-> !irq_tick) and (!ien[1] |-> !irq_lock) and (!ien[2] |-> !irq_scm));

    a_r5_frozen_full_stop: assert property (@(posedge clk) disable iff (rst)
        full_stop |-> !tick_exp);

    a_r6_pseudo_hold: assert property (@(posedge clk) disable iff (rst)
        (pseudo_stop && !psrun) |-> !tick_exp);

    a_r7_lock_chg_sets: assert property (@(posedge clk) disable iff (rst)
        lock_chg |=> flags[1]);

    a_r8_scm_chg_sets: assert property (@(posedge clk) disable iff (rst)
        scm_chg |=> flags[2]);
endmodule

bind cgen_irq_ctrl cgen_irq_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .full_stop   (full_stop),
    .pseudo_stop (pseudo_stop),
    .psrun       (ctl.psrun),
    .tick_exp    (tick_exp),
    .lock_chg    (lock_chg),
    .scm_chg     (scm_chg),
    .flags       (flags),
    .ien         ({ctl.scm_ie, ctl.lock_ie, ctl.tick_ie}),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .wdat        (bus_wdata[2:0]),
    .irq_tick    (irq_tick),
    .irq_lock    (irq_lock),
    .irq_scm     (irq_scm)
);

// File: tb/cgen_irq_ctrl_test.sv
`timescale 1ns/1ps
module cgen_irq_ctrl_test;
    localparam int PW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          lock_raw = 1'b0, scm_raw = 1'b0, ext_clk_lost = 1'b0;
    logic          full_stop = 1'b1, pseudo_stop = 1'b0;
    logic [PW-1:0] tick_period = 16'd4;
    logic          bus_wr = 1'b0, bus_addr = 1'b0;
    logic [4:0]    bus_wdata = '0;
    logic [4:0]    bus_rdata;
    logic          irq_tick, irq_lock, irq_scm;

    int vectors = 0;
    int errs    = 0;
    bit done    = 0;

    always #4 clk = ~clk;

    cgen_irq_ctrl #(.PW(PW)) uut (
        .clk(clk), .rst(rst), .lock_raw(lock_raw), .scm_raw(scm_raw),
        .ext_clk_lost(ext_clk_lost), .full_stop(full_stop), .pseudo_stop(pseudo_stop),
        .tick_period(tick_period), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_tick(irq_tick), .irq_lock(irq_lock), .irq_scm(irq_scm)
    );

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic a, input logic [4:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    function automatic logic [4:0] rd(input logic a);
        bus_addr = a;
        return bus_rdata;
    endfunction

    task automatic rd_flags(output logic [4:0] v);
        bus_addr = 1'b1; #1; v = bus_rdata;
    endtask

    task automatic rd_ctrl(output logic [4:0] v);
        bus_addr = 1'b0; #1; v = bus_rdata;
    endtask

    task automatic t_reset();
        logic [4:0] v;
        rd_ctrl(v);  chk("R10 ctrl after reset", v, 0);
        rd_flags(v); chk("R10 flags after reset", v, 0);
        chk("R4 no irq after reset", {irq_tick, irq_lock, irq_scm}, 0);
    endtask

    task automatic t_regs();
        logic [4:0] v;
        wr_reg(1'b0, 5'h17);
        rd_ctrl(v); chk("R10 ctrl readback", v, 'h17);
        wr_reg(1'b0, 5'h00);
        rd_ctrl(v); chk("R10 ctrl cleared", v, 0);
    endtask

    task automatic t_lock();
        logic [4:0] v;
        @(negedge clk); lock_raw = 1'b1;
        @(negedge clk); @(negedge clk);
        rd_flags(v); chk("R7 lock rise not before edge 3", v[1], 0);
        @(negedge clk);
        rd_flags(v); chk("R7 lock rise sets flag", v[1], 1);
        chk("R4 masked lock irq", irq_lock, 0);
        wr_reg(1'b0, 5'h02);
        #1 chk("R4 lock irq enabled", irq_lock, 1);
        wr_reg(1'b1, 5'h00);
        rd_flags(v); chk("R2 write 0 keeps lock flag", v[1], 1);
        wr_reg(1'b1, 5'h02);
        rd_flags(v); chk("R2 write 1 clears lock flag", v[1], 0);
        chk("R4 lock irq drops with flag", irq_lock, 0);
        lock_raw = 1'b0;
        repeat (3) @(negedge clk);
        rd_flags(v); chk("R7 lock fall sets flag", v[1], 1);
        wr_reg(1'b1, 5'h02);
        wr_reg(1'b0, 5'h00);
    endtask

    task automatic t_scm();
        logic [4:0] v;
        scm_raw = 1'b1;
        repeat (2) @(negedge clk);
        rd_flags(v); chk("R8 scm entry not before edge 3", v[2], 0);
        @(negedge clk);
        rd_flags(v); chk("R8 scm entry sets flag", v[2], 1);
        wr_reg(1'b0, 5'h04);
        #1 chk("R4 scm irq enabled", irq_scm, 1);
        wr_reg(1'b1, 5'h04);
        scm_raw = 1'b0;
        repeat (3) @(negedge clk);
        rd_flags(v); chk("R8 scm exit sets flag", v[2], 1);
        wr_reg(1'b1, 5'h04);
        wr_reg(1'b0, 5'h00);
    endtask

    task automatic t_monitor();
        logic [4:0] v;
        ext_clk_lost = 1'b1;
        repeat (6) @(negedge clk);
        rd_flags(v); chk("R9 clock loss ignored with monitor off", v[2], 0);
        wr_reg(1'b0, 5'h10);
        @(negedge clk);
        rd_flags(v); chk("R9 clock loss forces self-clock", v[2], 1);
        wr_reg(1'b1, 5'h04);
        ext_clk_lost = 1'b0;
        repeat (3) @(negedge clk);
        rd_flags(v); chk("R9 clock return leaves self-clock", v[2], 1);
        wr_reg(1'b0, 5'h00);
        wr_reg(1'b1, 5'h07);
    endtask

    task automatic count_tick(output int n);
        logic [4:0] v;
        n = 0;
        for (int i = 1; i <= 40; i++) begin
            @(negedge clk);
            rd_flags(v);
            if (v[0]) begin n = i; break; end
        end
    endtask

    task automatic t_tick();
        logic [4:0] v;
        int n;
        tick_period = 16'd4;
        repeat (2) @(negedge clk);
        wr_reg(1'b1, 5'h07);
        full_stop = 1'b0;
        count_tick(n); chk("R1 first timeout after P+1 cycles", n, 5);
        wr_reg(1'b1, 5'h01);
        repeat (3) @(negedge clk);
        rd_flags(v); chk("R1 no early timeout", v[0], 0);
        chk("R4 masked tick irq", irq_tick, 0);
        wr_reg(1'b1, 5'h01);
        rd_flags(v); chk("R3 set wins over clear", v[0], 1);
        wr_reg(1'b0, 5'h01);
        #1 chk("R4 tick irq enabled", irq_tick, 1);
        wr_reg(1'b0, 5'h00);
        full_stop = 1'b1;
        @(negedge clk);
        wr_reg(1'b1, 5'h01);
        repeat (20) @(negedge clk);
        rd_flags(v); chk("R5 no tick in full stop", v[0], 0);
        full_stop = 1'b0; pseudo_stop = 1'b1;
        repeat (20) @(negedge clk);
        rd_flags(v); chk("R6 no tick in pseudo-stop without run bit", v[0], 0);
        wr_reg(1'b0, 5'h09);
        count_tick(n); chk("R6 pseudo-stop wakeup period", n, 5);
        chk("R6 wakeup irq", irq_tick, 1);
        full_stop = 1'b1; pseudo_stop = 1'b0;
        wr_reg(1'b0, 5'h00);
        wr_reg(1'b1, 5'h07);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_regs();
        t_lock();
        t_scm();
        t_monitor();
        t_tick();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
            $finish;
        end
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            done = 1;
            errs++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
            $finish;
        end
    end
endmodule